// File: doc/BRIEF.md
# Time-Slot Interchanger with Self-Clearing Control

This block takes a serial stream of words in repeating frames of `N_IN` slots and rebuilds each frame as an output frame of `M_OUT` slots (`M_OUT >= N_IN`). Any input word can be routed to any output slot. Input words are written into a capture buffer. When the last word of a frame arrives, the capture buffer is copied into a stationary hold buffer. The next output frame is then read from the hold buffer, so every word reaches the output one frame late and input words may arrive with idle gaps between them.

The routing is held in a control store with one entry per input word, and each entry names the output slot for that word. A connection is requested by timing, not by address. A pulse on `conn_src` during input word n selects the source. A later pulse on `conn_dst` during output slot m selects the destination. Entries remove themselves: an input word that arrives with its busy flag (the most significant bit) low loses its entry. A pulse on `erase_word` during input word n also clears that word's entry. Entries that are not changed stay in force frame after frame.

Top module: `slot_interchanger`

## Requirements
- R1: While reset is asserted and afterwards until the first completed input frame, `out_valid`, `out_sof` are 0 and `out_word` is all zeros; reset also clears every connection and any pending source selection.
- R2: The cycle after the input word in slot N_IN-1 is accepted (slot 0 is the word carrying `in_sof`), an output frame of exactly M_OUT cycles begins, with `out_sof` high only in its first cycle and `out_valid` high throughout.
- R3: In output slot m, a word connected to slot m is delivered exactly as it was captured in the previous input frame, busy flag (bit WORD_W-1) included.
- R4: An output slot with no connected input word emits an all-zero word (busy flag 0), and `out_word` is zero whenever `out_valid` is low.
- R5: A `conn_src` pulse on a valid input word n, followed by a `conn_dst` pulse in output slot m, connects n to m; the connection shows from the next output frame on.
- R6: Connecting input word n again removes its previous destination.
- R7: Connecting a word to slot m removes any other word's connection to slot m, so each slot has at most one source.
- R8: An input word n that arrives with busy flag 0 loses its connection; it stays disconnected after the flag returns to 1.
- R9: An `erase_word` pulse on valid input word n removes n's connection.
- R10: Connections not touched by R6 to R9 repeat unchanged in every following frame.
- R11: Cycles with `in_valid` low neither advance the input slot count nor alter captured words; a `conn_dst` pulse outside an output frame, or with no pending source, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word present this cycle |
| in_sof | input | 1 | Marks the word in input slot 0 |
| in_word | input | WORD_W | Input word, MSB is the busy flag |
| conn_src | input | 1 | Timed pulse selecting the source input word |
| conn_dst | input | 1 | Timed pulse selecting the destination output slot |
| erase_word | input | 1 | Timed pulse clearing the current input word's connection |
| out_valid | output | 1 | Output frame in progress |
| out_sof | output | 1 | First slot of an output frame |
| out_word | output | WORD_W | Rearranged output word |

## Verification
The assertions assume that `in_sof` comes only with a valid word and that input frames always run for the full N_IN words. They also assume a new input frame does not finish while an output frame is still running, so the hold buffer stays stable during its frame. The stimulus spaces input frames M_OUT+2 cycles apart, drives every frame from slot 0 to slot N_IN-1, and issues `conn_dst` only in defined output slots, except for one deliberate pulse while the output is idle.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  // Index width for a count of n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tsi_in_capture.sv
module tsi_in_capture #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned IW    = tsi_pkg::idx_w(N_IN)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  input  logic                         in_sof,
  input  logic [WORD_W-1:0]            in_word,
  output logic [IW-1:0]                cur_slot,
  output logic                         frame_done,
  output logic [N_IN-1:0][WORD_W-1:0]  hold
);
  localparam logic [IW-1:0] LAST = IW'(N_IN - 1);

  logic [IW-1:0]               slot_q, slot_d;
  logic [N_IN-1:0][WORD_W-1:0] cap_q;
  logic [N_IN-1:0][WORD_W-1:0] hold_q;

  always_comb begin
    cur_slot   = in_sof ? '0 : slot_q;
    frame_done = in_valid && (cur_slot == LAST);
    slot_d     = slot_q;
    if (in_valid) slot_d = (cur_slot == LAST) ? '0 : cur_slot + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_q <= '0;
    else        slot_q <= slot_d;
  end

  // Data storage carries no reset; it is qualified by the control store.
  generate
    for (genvar i = 0; i < N_IN; i++) begin : g_word
      always_ff @(posedge clk) begin
        if (in_valid && (cur_slot == IW'(i))) cap_q[i] <= in_word;
      end
      always_ff @(posedge clk) begin
        if (frame_done) hold_q[i] <= (i == N_IN - 1) ? in_word : cap_q[i];
      end
    end
  endgenerate

  assign hold = hold_q;
endmodule

// File: rtl/tsi_ctrl_store.sv
module tsi_ctrl_store #(
  parameter int unsigned N_IN  = 4,
  parameter int unsigned M_OUT = 6,
  localparam int unsigned IW   = tsi_pkg::idx_w(N_IN),
  localparam int unsigned OW   = tsi_pkg::idx_w(M_OUT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [IW-1:0]   cur_slot,
  input  logic            busy_bit,
  input  logic            src_pulse,
  input  logic            erase_pulse,
  input  logic            out_act,
  input  logic [OW-1:0]   out_slot,
  input  logic            dst_pulse,
  output logic            hit,
  output logic [IW-1:0]   hit_src,
  output logic [N_IN-1:0] vld_vec,
  output logic [N_IN-1:0] match_vec,
  output logic            wr_en
);
  logic [N_IN-1:0]           ent_v_q, ent_v_d;
  logic [N_IN-1:0][OW-1:0]   ent_d_q, ent_d_d;
  logic                      pend_v_q, pend_v_d;
  logic [IW-1:0]             pend_n_q, pend_n_d;

  assign wr_en = dst_pulse && out_act && pend_v_q;

  always_comb begin
    ent_v_d  = ent_v_q;
    ent_d_d  = ent_d_q;
    pend_v_d = pend_v_q;
    pend_n_d = pend_n_q;
    for (int i = 0; i < N_IN; i++) begin
      if (in_valid && (cur_slot == IW'(i)) && (!busy_bit || erase_pulse))
        ent_v_d[i] = 1'b0;
      if (wr_en) begin
        if (pend_n_q == IW'(i)) begin
          ent_v_d[i] = 1'b1;
          ent_d_d[i] = out_slot;
        end else if (ent_d_q[i] == out_slot) begin
          ent_v_d[i] = 1'b0;
        end
      end
    end
    if (wr_en) pend_v_d = 1'b0;
    if (src_pulse && in_valid) begin
      pend_v_d = 1'b1;
      pend_n_d = cur_slot;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v_q  <= '0;
      pend_v_q <= 1'b0;
    end else begin
      ent_v_q  <= ent_v_d;
      pend_v_q <= pend_v_d;
    end
  end

  always_ff @(posedge clk) begin
    ent_d_q  <= ent_d_d;
    pend_n_q <= pend_n_d;
  end

  always_comb begin
    hit_src = '0;
    for (int i = 0; i < N_IN; i++) begin
      match_vec[i] = ent_v_q[i] && (ent_d_q[i] == out_slot);
      if (match_vec[i]) hit_src = IW'(i);
    end
    hit     = out_act && (|match_vec);
    vld_vec = ent_v_q;
  end
endmodule

// File: rtl/tsi_out_seq.sv
module tsi_out_seq #(
  parameter int unsigned M_OUT = 6,
  localparam int unsigned OW   = tsi_pkg::idx_w(M_OUT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          out_act,
  output logic [OW-1:0] out_slot,
  output logic          out_sof
);
  localparam logic [OW-1:0] LAST = OW'(M_OUT - 1);

  logic          act_q, act_d;
  logic [OW-1:0] slot_q, slot_d;

  always_comb begin
    act_d  = act_q;
    slot_d = slot_q;
    if (start) begin
      act_d  = 1'b1;
      slot_d = '0;
    end else if (act_q) begin
      if (slot_q == LAST) act_d = 1'b0;
      else                slot_d = slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      slot_q <= '0;
    end else begin
      act_q  <= act_d;
      slot_q <= slot_d;
    end
  end

  assign out_act  = act_q;
  assign out_slot = slot_q;
  assign out_sof  = act_q && (slot_q == '0);
endmodule

// File: rtl/slot_interchanger.sv
module slot_interchanger #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned M_OUT  = 6,
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [WORD_W-1:0] in_word,
  input  logic              conn_src,
  input  logic              conn_dst,
  input  logic              erase_word,
  output logic              out_valid,
  output logic              out_sof,
  output logic [WORD_W-1:0] out_word
);
  localparam int unsigned IW = tsi_pkg::idx_w(N_IN);
  localparam int unsigned OW = tsi_pkg::idx_w(M_OUT);

  logic [IW-1:0]               cur_slot;
  logic                        frame_done;
  logic [N_IN-1:0][WORD_W-1:0] hold;
  logic                        out_act;
  logic [OW-1:0]               out_slot;
  logic                        hit;
  logic [IW-1:0]               hit_src;
  logic [N_IN-1:0]             vld_vec;
  logic [N_IN-1:0]             match_vec;
  logic                        wr_en;

  tsi_in_capture #(.N_IN(N_IN), .WORD_W(WORD_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_word(in_word), .cur_slot(cur_slot), .frame_done(frame_done), .hold(hold)
  );

  tsi_ctrl_store #(.N_IN(N_IN), .M_OUT(M_OUT)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_slot(cur_slot),
    .busy_bit(in_word[WORD_W-1]), .src_pulse(conn_src), .erase_pulse(erase_word),
    .out_act(out_act), .out_slot(out_slot), .dst_pulse(conn_dst),
    .hit(hit), .hit_src(hit_src), .vld_vec(vld_vec), .match_vec(match_vec),
    .wr_en(wr_en)
  );

  tsi_out_seq #(.M_OUT(M_OUT)) u_out (
    .clk(clk), .rst_n(rst_n), .start(frame_done),
    .out_act(out_act), .out_slot(out_slot), .out_sof(out_sof)
  );

  assign out_valid = out_act;
  assign out_word  = hit ? hold[hit_src] : '0;
endmodule

// File: rtl/slot_interchanger_chk.sv
module slot_interchanger_chk #(
  parameter int unsigned N_IN   = 4,
  parameter int unsigned M_OUT  = 6,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned IW    = tsi_pkg::idx_w(N_IN)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [WORD_W-1:0] in_word,
  input logic              out_valid,
  input logic              out_sof,
  input logic [WORD_W-1:0] out_word,
  input logic              frame_done,
  input logic [IW-1:0]     cur_slot,
  input logic [N_IN-1:0]   vld_vec,
  input logic [N_IN-1:0]   match_vec,
  input logic              wr_en
);
  assert_sof_in_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);

  assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> out_sof);

  assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_word == '0));

  assert_one_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match_vec));

  assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_word[WORD_W-1] && !wr_en) |=> !vld_vec[$past(cur_slot)]);
endmodule

bind slot_interchanger slot_interchanger_chk #(
  .N_IN(N_IN), .M_OUT(M_OUT), .WORD_W(WORD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
  .out_valid(out_valid), .out_sof(out_sof), .out_word(out_word),
  .frame_done(frame_done), .cur_slot(cur_slot), .vld_vec(vld_vec),
  .match_vec(match_vec), .wr_en(wr_en)
);

// File: tb/slot_interchanger_bench.sv
`timescale 1ns/1ps
module slot_interchanger_bench;
  localparam int N = 4;
  localparam int M = 6;
  localparam int W = 8;
  localparam int ROWS = 10;
  // Columns: source word, destination slot, erase word, busy mask (-1 = none)
  localparam int TBL [ROWS][4] = '{
    '{ 1,  3, -1, 15},   // R5 connect 1->3, visible next frame
    '{-1, -1, -1, 15},   // R3 R10 mapping repeats
    '{ 2,  0, -1, 15},   // R5 second connection
    '{ 1,  5, -1, 15},   // R6 reconnect word 1
    '{-1, -1, -1, 15},   // R6 old slot 3 now empty
    '{ 3,  5, -1, 15},   // R7 word 3 evicts word 1 from slot 5
    '{ 0,  2, -1, 11},   // R8 word 2 idle this frame
    '{-1, -1, -1, 15},   // R8 word 2 stays dropped
    '{-1, -1,  3, 15},   // R9 erase word 3
    '{ 2,  4, -1, 15}    // R5 reconnect a dropped word
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid, in_sof, conn_src, conn_dst, erase_word;
  logic [W-1:0] in_word;
  logic out_valid, out_sof;
  logic [W-1:0] out_word;

  int checks = 0;
  int fails  = 0;
  int fr     = 0;
  int mdl [N];
  int pend_v = 0;
  int pend_n = 0;

  always #10 clk = ~clk;

  slot_interchanger #(.N_IN(N), .M_OUT(M), .WORD_W(W)) u_slot_interchanger (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_word(in_word), .conn_src(conn_src), .conn_dst(conn_dst),
    .erase_word(erase_word), .out_valid(out_valid), .out_sof(out_sof),
    .out_word(out_word)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s frame %0d: got %h expected %h", req, fr, got, exp);
    end
  endtask

  task automatic idle_inputs();
    in_valid = 0; in_sof = 0; in_word = '0;
    conn_src = 0; conn_dst = 0; erase_word = 0;
  endtask

  function automatic logic [W-1:0] mk_word(input int n, input int mask);
    return {mask[n] ? 1'b1 : 1'b0, 7'((fr % 15) * 8 + n + 1)};
  endfunction

  // One input frame, then its output frame, with model update and checks.
  task automatic run_frame(input int src, input int dst, input int ers,
                           input int mask, input int gap_at);
    logic [W-1:0] words [N];
    logic [W-1:0] exp;
    for (int n = 0; n < N; n++) begin
      if (n == gap_at) begin
        @(negedge clk); idle_inputs();          // R11 idle cycle mid-frame
      end
      @(negedge clk);
      words[n]   = mk_word(n, mask);
      in_valid   = 1; in_sof = (n == 0); in_word = words[n];
      conn_src   = (n == src); erase_word = (n == ers); conn_dst = 0;
      if (!mask[n] || n == ers) mdl[n] = -1;
      if (n == src) begin pend_v = 1; pend_n = n; end
    end
    for (int s = 0; s < M; s++) begin
      @(negedge clk);
      idle_inputs();
      conn_dst = (s == dst);
      exp = '0;
      for (int n = 0; n < N; n++) if (mdl[n] == s) exp = words[n];
      check("R2", {7'd0, out_valid}, 8'd1);
      check("R2", {7'd0, out_sof}, {7'd0, s == 0});
      check(exp == '0 ? "R4" : "R3", out_word, exp);
      if (s == dst && pend_v == 1) begin
        for (int n = 0; n < N; n++) if (mdl[n] == s) mdl[n] = -1;
        mdl[pend_n] = s;
        pend_v = 0;
      end
    end
    @(negedge clk);
    idle_inputs();
    check("R2", {7'd0, out_valid}, 8'd0);
    check("R4", out_word, '0);
    @(negedge clk);
    fr++;
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int n = 0; n < N; n++) mdl[n] = -1;
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1", {6'd0, out_valid, out_sof}, 8'd0);
    check("R1", out_word, '0);
    rst_n = 1;
    @(negedge clk);
    check("R1", {6'd0, out_valid, out_sof}, 8'd0);

    for (int r = 0; r < ROWS; r++)
      run_frame(TBL[r][0], TBL[r][1], TBL[r][2], TBL[r][3], -1);

    // R11: source pending, then a destination pulse while output is idle.
    run_frame(1, -1, -1, 15, -1);
    @(negedge clk); conn_dst = 1;
    @(negedge clk); conn_dst = 0;
    run_frame(-1, -1, -1, 15, -1);              // R11 nothing changed
    run_frame(-1, 1, -1, 15, -1);               // R5 pending source now lands
    run_frame(-1, -1, -1, 15, -1);              // R3 word 1 in slot 1
    // R11: destination pulse with no pending source is ignored.
    run_frame(-1, 3, -1, 15, -1);
    run_frame(-1, -1, -1, 15, 2);               // R11 gap inside input frame

    // R1: reset mid-run clears every connection.
    rst_n = 0;
    @(negedge clk);
    check("R1", {6'd0, out_valid, out_sof}, 8'd0);
    rst_n = 1;
    for (int n = 0; n < N; n++) mdl[n] = -1;
    pend_v = 0;
    run_frame(-1, -1, -1, 15, -1);              // R1 all slots zero

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule